// File: doc/BRIEF.md
# Pulse-Mode Gain Stepper

This block keeps the 6-bit attenuation code for one channel of a digitally stepped gain stage. Code 0 is the highest gain. Each code unit is 0.5 dB, so the range of 0 to 63 covers 31.5 dB. Two active-low strobe inputs move the code. A low pulse on the up strobe raises the gain, which lowers the code. A low pulse on the down strobe lowers the gain, which raises the code. A 2-bit select input sets how far each pulse moves the code.

The strobes come from another clock domain, so they are first brought into the system clock through a synchronizer. The block then measures each low phase and the high phase before it, in system-clock cycles. It acts only on a pulse that meets both minimum widths, and it applies the step when the strobe is released. If both strobes are held low together long enough, the code returns to 0, and neither strobe of that overlap also steps the code.

While the channel is disabled, the code is frozen and the strobes have no effect. The enable is passed straight through for use by the analog side.

Top module: `gain_pulse_stepper`

## Requirements
- R1: While rst_n is low, and on release from reset, atten_o is 0.
- R2: A qualified up pulse lowers atten_o by the selected step on its release. The result floors at 0.
- R3: A qualified down pulse raises atten_o by the selected step on its release. The result caps at 63.
- R4: The step is sampled when the strobe is released. The encoding is step_sel_i = 2'b00 for 1 code (0.5 dB), 2'b01 for 2 codes, 2'b10 for 4 codes and 2'b11 for 12 codes (6 dB).
- R5: A low phase shorter than MIN_LOW_CYC system cycles has no effect on atten_o. A low phase of exactly MIN_LOW_CYC cycles counts.
- R6: A pulse whose preceding high phase is shorter than MIN_GAP_CYC cycles has no effect. A high phase of exactly MIN_GAP_CYC cycles counts.
- R7: When both strobes are low together for MIN_OVL_CYC cycles, atten_o becomes 0. The releases of both strobes that took part in that overlap cause no step.
- R8: atten_o saturates and never wraps: from 63 a down pulse leaves 63, and from 0 an up pulse leaves 0.
- R9: While en_i is low, atten_o holds its value, and strobes and overlaps have no effect. On re-enable the held value is still in place.
- R10: en_o equals en_i in every cycle.
- R11: An overlap shorter than MIN_OVL_CYC does not reset the code. Each strobe then steps on its own release, using the step select present at that release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable; when low, the code is frozen |
| up_n_i | input | 1 | Active-low strobe that raises the gain |
| dn_n_i | input | 1 | Active-low strobe that lowers the gain |
| step_sel_i | input | 2 | Step size select, encoded as in R4 |
| atten_o | output | 6 | Current attenuation code; 0 is maximum gain |
| en_o | output | 1 | Pass-through of en_i |

## Verification
The bench drives low phases and gaps of exactly the minimum width and one cycle below it. An off-by-one width comparison would drop the legal pulse or accept the runt. It holds the overlap at exactly the reset threshold, then releases the strobes one after the other. A design that forgets the overlap when the first strobe releases would step the code by one away from 0 after the reset. A shorter overlap with the step select changed between the two releases catches a false reset, and also a step size latched at press time instead of at release. Saturation is driven from both ends so that any wrap shows up. Strobes and overlaps sent while disabled must leave the code untouched.

// File: rtl/gps_pkg.sv
package gps_pkg;
   typedef enum logic [1:0] {
      STEP_HALF_DB = 2'b00,
      STEP_ONE_DB  = 2'b01,
      STEP_TWO_DB  = 2'b10,
      STEP_SIX_DB  = 2'b11
   } step_sel_t;

   localparam int STEP_LSB_MAX = 12;

   function automatic logic [3:0] step_lsb(input logic [1:0] sel);
      case (step_sel_t'(sel))
         STEP_HALF_DB: step_lsb = 4'd1;
         STEP_ONE_DB:  step_lsb = 4'd2;
         STEP_TWO_DB:  step_lsb = 4'd4;
         default:      step_lsb = 4'd12;
      endcase
   endfunction
endpackage

// File: rtl/gps_sync.sv
module gps_sync #(
   parameter int STAGES    = 2,
   parameter int WIDTH     = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= {STAGES{{WIDTH{RST_VAL}}}};
            end else begin
               chain_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gps_strobe_qual.sv
module gps_strobe_qual #(
   parameter int MIN_LOW = 4,
   parameter int MIN_GAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic low_o,
   output logic release_o
);
   localparam int LONGEST = (MIN_LOW > MIN_GAP) ? MIN_LOW : MIN_GAP;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] LOW_TH  = CNT_W'(MIN_LOW);
   localparam logic [CNT_W-1:0] GAP_TH  = CNT_W'(MIN_GAP);

   logic             lvl_q;
   logic [CNT_W-1:0] run_q;
   logic             gap_ok_q;
   logic             edge_seen;

   assign edge_seen = (lvl_i != lvl_q);
   assign low_o     = ~lvl_i;
   assign release_o = edge_seen && lvl_i && gap_ok_q && (run_q >= LOW_TH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= 1'b1;
         run_q    <= CNT_MAX;
         gap_ok_q <= 1'b0;
      end else if (edge_seen) begin
         lvl_q <= lvl_i;
         run_q <= CNT_W'(1);
         if (!lvl_i) gap_ok_q <= (run_q >= GAP_TH);
      end else if (run_q != CNT_MAX) begin
         run_q <= run_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/gps_step_engine.sv
module gps_step_engine
   import gps_pkg::*;
#(
   parameter int CODE_W  = 6,
   parameter int MIN_OVL = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              up_low_i,
   input  logic              dn_low_i,
   input  logic              up_rel_i,
   input  logic              dn_rel_i,
   input  logic [1:0]        step_sel_i,
   output logic              fire_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int OVL_W = $clog2(MIN_OVL + 1);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;
   localparam logic [OVL_W-1:0]  OVL_LAST = OVL_W'(MIN_OVL - 1);
   localparam logic [OVL_W-1:0]  OVL_SAT  = OVL_W'(MIN_OVL);

   logic [OVL_W-1:0]  ovl_q;
   logic              ovl_seen_q;
   logic              both_low, take_up, take_dn;
   logic [CODE_W-1:0] code_q, code_d, stp;
   logic [CODE_W:0]   sum;

   assign both_low = up_low_i && dn_low_i;
   assign fire_o   = both_low && (ovl_q == OVL_LAST);
   assign take_up  = en_i && up_rel_i && !dn_rel_i && !ovl_seen_q;
   assign take_dn  = en_i && dn_rel_i && !up_rel_i && !ovl_seen_q;
   assign stp      = CODE_W'(step_lsb(step_sel_i));
   assign sum      = {1'b0, code_q} + {1'b0, stp};

   always_comb begin
      code_d = code_q;
      if (en_i && fire_o)  code_d = '0;
      else if (take_up)    code_d = (code_q >= stp) ? (code_q - stp) : '0;
      else if (take_dn)    code_d = sum[CODE_W] ? CODE_MAX : sum[CODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovl_q      <= '0;
         ovl_seen_q <= 1'b0;
         code_q     <= '0;
      end else begin
         code_q <= code_d;
         if (!both_low)           ovl_q <= '0;
         else if (ovl_q != OVL_SAT) ovl_q <= ovl_q + OVL_W'(1);
         if (fire_o)                     ovl_seen_q <= 1'b1;
         else if (!up_low_i && !dn_low_i) ovl_seen_q <= 1'b0;
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/gain_pulse_stepper.sv
module gain_pulse_stepper #(
   parameter int CODE_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW_CYC = 4,
   parameter int MIN_GAP_CYC = 4,
   parameter int MIN_OVL_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              up_n_i,
   input  logic              dn_n_i,
   input  logic [1:0]        step_sel_i,
   output logic [CODE_W-1:0] atten_o,
   output logic              en_o
);
   generate
      if (CODE_W < 5)      begin : g_bad_w   $error("CODE_W must hold the largest step"); end
      if (MIN_LOW_CYC < 1) begin : g_bad_low $error("MIN_LOW_CYC must be positive"); end
      if (MIN_GAP_CYC < 1) begin : g_bad_gap $error("MIN_GAP_CYC must be positive"); end
      if (MIN_OVL_CYC < 1) begin : g_bad_ovl $error("MIN_OVL_CYC must be positive"); end
   endgenerate

   logic [1:0] strobe_s;
   logic       up_low, dn_low, up_rel, dn_rel;
   logic       reset_fire;

   gps_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({up_n_i, dn_n_i}), .q_o(strobe_s));

   gps_strobe_qual #(.MIN_LOW(MIN_LOW_CYC), .MIN_GAP(MIN_GAP_CYC)) u_qual_up (
      .clk(clk), .rst_n(rst_n), .lvl_i(strobe_s[1]), .low_o(up_low), .release_o(up_rel));

   gps_strobe_qual #(.MIN_LOW(MIN_LOW_CYC), .MIN_GAP(MIN_GAP_CYC)) u_qual_dn (
      .clk(clk), .rst_n(rst_n), .lvl_i(strobe_s[0]), .low_o(dn_low), .release_o(dn_rel));

   gps_step_engine #(.CODE_W(CODE_W), .MIN_OVL(MIN_OVL_CYC)) u_engine (
      .clk(clk), .rst_n(rst_n), .en_i(en_i),
      .up_low_i(up_low), .dn_low_i(dn_low), .up_rel_i(up_rel), .dn_rel_i(dn_rel),
      .step_sel_i(step_sel_i), .fire_o(reset_fire), .code_o(atten_o));

   assign en_o = en_i;
endmodule

// File: rtl/gps_checker.sv
module gps_checker #(
   parameter int CODE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic              en_o,
   input logic              fire,
   input logic [CODE_W-1:0] atten_o
);
   localparam logic [CODE_W-1:0] CMAX = '1;
   localparam logic [CODE_W-1:0] BIG  = CODE_W'(gps_pkg::STEP_LSB_MAX);

   function automatic logic legal_move(input logic [CODE_W-1:0] a, input logic [CODE_W-1:0] b);
      logic [CODE_W-1:0] d;
      d = (a > b) ? (a - b) : (b - a);
      return (a == b) || (b == '0) || (b == CMAX) ||
             (d == CODE_W'(1)) || (d == CODE_W'(2)) || (d == CODE_W'(4)) || (d == BIG);
   endfunction

   p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(atten_o));

   p_enable_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      en_o == en_i);

   p_overlap_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && en_i) |=> (atten_o == '0));

   p_step_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> legal_move($past(atten_o), atten_o));

   p_no_wrap_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (atten_o == '0) |=> (atten_o <= BIG));

   p_no_wrap_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (atten_o == CMAX) |=> ((atten_o >= CMAX - BIG) || (atten_o == '0)));

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_zero_r1: assert (atten_o == '0);
      end
   end
endmodule

bind gain_pulse_stepper gps_checker #(.CODE_W(CODE_W)) u_gps_checker (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .en_o(en_o), .fire(reset_fire), .atten_o(atten_o));

// File: tb/gain_pulse_stepper_bench.sv
module gain_pulse_stepper_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b1;
   logic       up_n = 1'b1;
   logic       dn_n = 1'b1;
   logic [1:0] sel = 2'b00;
   logic [5:0] atten;
   logic       en_o;
   int         n_checks = 0;
   int         n_fail   = 0;
   bit         done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gain_pulse_stepper u_gain_pulse_stepper (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .up_n_i(up_n), .dn_n_i(dn_n),
      .step_sel_i(sel), .atten_o(atten), .en_o(en_o));

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_code(input logic [5:0] exp, input string req);
      n_checks++;
      if (atten !== exp) begin
         n_fail++;
         $display("FAIL %s: atten_o=%0d expected=%0d", req, atten, exp);
      end
   endtask

   task automatic check_en(input logic exp, input string req);
      n_checks++;
      if (en_o !== exp) begin
         n_fail++;
         $display("FAIL %s: en_o=%0b expected=%0b", req, en_o, exp);
      end
   endtask

   task automatic pulse(input bit is_up, input int low_len, input logic [1:0] s);
      sel = s;
      if (is_up) up_n = 1'b0; else dn_n = 1'b0;
      wait_cyc(low_len);
      up_n = 1'b1; dn_n = 1'b1;
      wait_cyc(SETTLE);
   endtask

   task automatic t_reset;
      wait_cyc(3);
      check_code(6'd0, "R1 in reset");
      rst_n = 1'b1;
      wait_cyc(2);
      check_code(6'd0, "R1 after reset");
      check_en(1'b1, "R10 enabled");
   endtask

   task automatic t_steps;
      pulse(1'b0, 4, 2'b00); check_code(6'd1,  "R3 R4 down half step");
      pulse(1'b0, 4, 2'b01); check_code(6'd3,  "R3 R4 down 1dB");
      pulse(1'b0, 5, 2'b10); check_code(6'd7,  "R3 R4 down 2dB");
      pulse(1'b0, 4, 2'b11); check_code(6'd19, "R3 R4 down 6dB");
      pulse(1'b1, 4, 2'b11); check_code(6'd7,  "R2 R4 up 6dB");
      pulse(1'b1, 6, 2'b10); check_code(6'd3,  "R2 R4 up 2dB");
   endtask

   task automatic t_width;
      pulse(1'b0, 3, 2'b00); check_code(6'd3, "R5 runt down ignored");
      pulse(1'b1, 1, 2'b00); check_code(6'd3, "R5 runt up ignored");
   endtask

   task automatic t_gap;
      sel = 2'b00;
      dn_n = 1'b0; wait_cyc(4); dn_n = 1'b1; wait_cyc(3);
      dn_n = 1'b0; wait_cyc(4); dn_n = 1'b1; wait_cyc(SETTLE);
      check_code(6'd4, "R6 short gap second pulse ignored");
      dn_n = 1'b0; wait_cyc(4); dn_n = 1'b1; wait_cyc(4);
      dn_n = 1'b0; wait_cyc(4); dn_n = 1'b1; wait_cyc(SETTLE);
      check_code(6'd6, "R6 exact gap both count");
   endtask

   task automatic t_saturate_high;
      for (int i = 0; i < 4; i++) pulse(1'b0, 4, 2'b11);
      check_code(6'd54, "R3 climb");
      pulse(1'b0, 4, 2'b11); check_code(6'd63, "R8 cap at 63");
      pulse(1'b0, 4, 2'b11); check_code(6'd63, "R8 no wrap at 63");
   endtask

   task automatic t_overlap_reset;
      sel = 2'b00;
      up_n = 1'b0; wait_cyc(2);
      dn_n = 1'b0; wait_cyc(4);
      up_n = 1'b1; wait_cyc(2);
      dn_n = 1'b1; wait_cyc(SETTLE);
      check_code(6'd0, "R7 overlap reset with no trailing step");
      pulse(1'b1, 4, 2'b00); check_code(6'd0, "R8 floor at 0");
   endtask

   task automatic t_overlap_short;
      pulse(1'b0, 4, 2'b10);
      pulse(1'b0, 4, 2'b10);
      check_code(6'd8, "R11 setup");
      sel = 2'b10;
      up_n = 1'b0; wait_cyc(3);
      dn_n = 1'b0; wait_cyc(3);
      up_n = 1'b1; wait_cyc(3);
      sel = 2'b00; wait_cyc(3);
      dn_n = 1'b1; wait_cyc(SETTLE);
      check_code(6'd5, "R11 short overlap steps each strobe");
   endtask

   task automatic t_disable;
      en_i = 1'b0; wait_cyc(1);
      check_en(1'b0, "R10 disabled");
      pulse(1'b0, 5, 2'b11);
      check_code(6'd5, "R9 strobe ignored while disabled");
      up_n = 1'b0; dn_n = 1'b0; wait_cyc(6);
      up_n = 1'b1; dn_n = 1'b1; wait_cyc(SETTLE);
      check_code(6'd5, "R9 overlap ignored while disabled");
      en_i = 1'b1; wait_cyc(2);
      check_code(6'd5, "R9 held value after enable");
      pulse(1'b0, 4, 2'b00);
      check_code(6'd6, "R9 stepping resumes");
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_steps();
      t_width();
      t_gap();
      t_saturate_high();
      t_overlap_reset();
      t_overlap_short();
      t_disable();
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      finish_run();
   end
endmodule